// File: doc/BRIEF.md
# External Interrupt Request Flag Unit

This block gathers six external interrupt pins into two byte-wide registers on a simple processor register bus. Each pin passes through a synchroniser. A per-channel sense input then selects how the pin is detected: level-low or falling edge. A detected condition sets that channel's request flag. The flag stays set until one of two things clears it. Software can read the flag as 1 and then write 0 to it. Otherwise the interrupt handling logic sends a one-cycle acknowledge.

A second register holds one enable bit per channel. The block drives one request line per channel, and that line is high only while the channel's flag and its enable bit are both set. Vector generation, priority arbitration and the register holding the sense selects sit outside the block.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the enable register and the status flags are zero, both registers read 0x00 and every request output is low.
- R2: The enable register is at address 0xF5 and the status register at 0xF6. Channel n maps to data bit n for bits 5..0, and bits 7 and 6 read as 0. Read data follows the address in the same cycle. Any other address reads 0x00.
- R3: Request output n is high exactly when flag n and enable bit n are both 1.
- R4: With sense bit n at 0 (level mode), flag n is set while the synchronised pin is low. The synchronisers reset high. A pin change made before rising edge k reaches the flag at edge k+2, through two synchroniser flops and the flag flop.
- R5: With sense bit n at 1 (edge mode), flag n is set once for each high-to-low change of the synchronised pin. A pin that stays low does not set the flag again.
- R6: Writing 1 to a status bit never changes that flag.
- R7: A read of 0xF6 with the read strobe arms every flag that reads 1. A later write of 0 clears only an armed flag. Any write to 0xF6 disarms all channels, and a hardware clear disarms its own channel.
- R8: In level mode, acknowledge pulse n clears flag n only when the synchronised pin is high in that cycle.
- R9: In edge mode, acknowledge pulse n always clears flag n.
- R10: When a set condition and a clear fall in the same cycle, the flag ends up set.
- R11: A write to 0xF5 stores data bits 5..0 as the channel enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read (arms flags) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| irqPin | input | 6 | External interrupt pins, asynchronous |
| senseEdge | input | 6 | Per-channel sense select: 0 level-low, 1 falling edge |
| ackPulse | input | 6 | Per-channel handling acknowledge, one-cycle pulse |
| irqReq | output | 6 | Masked request per channel |

## Verification
The bench builds the block with its default parameters: six channels, an 8-bit bus and two synchroniser stages. With those values it can cover the exact three-edge latency from pin to flag. It can also cover a falling edge that meets an acknowledge in the same cycle, and the difference between a level-mode acknowledge given while the pin is low and one given after the pin has gone high. The random phase varies the sense selects channel by channel, so level and edge channels run side by side. It also mixes reads, writes of 0 and writes of 1 to the status register, so that arming and disarming happen in many different orders.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  // Decoded bus strobes passed from control to datapath
  typedef struct packed {
    logic enWr;   // write of the enable register
    logic stWr;   // write of the status register
    logic stRd;   // read of the status register (arms flags)
    logic selEn;  // read mux selects the enable register
    logic selSt;  // read mux selects the status register
  } busStrobe_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  // Stages reset high so the idle pin level shows no edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '1;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ext_irq_ctl.sv
module ext_irq_ctl
  import ext_irq_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'hF5,
  parameter logic [ADDR_W-1:0] ST_ADDR = 8'hF6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output busStrobe_t        strb
);
  logic hitEn, hitSt;

  assign hitEn = (busAddr == EN_ADDR);
  assign hitSt = (busAddr == ST_ADDR);

  always_comb begin
    strb.selEn = hitEn;
    strb.selSt = hitSt;
    strb.enWr  = busWrEn & hitEn;
    strb.stWr  = busWrEn & hitSt;
    strb.stRd  = busRdEn & hitSt;
  end
endmodule

// File: rtl/ext_irq_dp.sv
module ext_irq_dp
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] irqPin,
  input  logic [NUM_CH-1:0] senseEdge,
  input  logic [NUM_CH-1:0] ackPulse,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irqReq
);
  localparam int PAD_W = DATA_W - NUM_CH;

  logic [NUM_CH-1:0] syncQ, prevQ;
  logic [NUM_CH-1:0] flagQ, flagD, armQ, armD, enQ;

  ext_irq_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (irqPin),
    .dout(syncQ)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic setC, hwC, swC;
    // level mode: low sample; edge mode: high-to-low between samples
    assign setC = senseEdge[i] ? (prevQ[i] & ~syncQ[i]) : ~syncQ[i];
    // level-mode acknowledge needs the pin back high
    assign hwC  = ackPulse[i] & (senseEdge[i] | syncQ[i]);
    assign swC  = strb.stWr & ~wdata[i] & armQ[i];
    // set has priority over both clears
    assign flagD[i] = setC | (flagQ[i] & ~(hwC | swC));
    assign armD[i]  = strb.stWr ? 1'b0
                    : ((armQ[i] | (strb.stRd & flagQ[i])) & ~hwC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= '1;
      flagQ <= '0;
      armQ  <= '0;
      enQ   <= '0;
    end else begin
      prevQ <= syncQ;
      flagQ <= flagD;
      armQ  <= armD;
      if (strb.enWr) enQ <= wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (strb.selEn)      rdata = {{PAD_W{1'b0}}, enQ};
    else if (strb.selSt) rdata = {{PAD_W{1'b0}}, flagQ};
  end

  assign irqReq = flagQ & enQ;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int              NUM_CH      = 6,
  parameter int              DATA_W      = 8,
  parameter int              ADDR_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] EN_ADDR     = 8'hF5,
  parameter logic [ADDR_W-1:0] ST_ADDR     = 8'hF6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_CH-1:0] irqPin,
  input  logic [NUM_CH-1:0] senseEdge,
  input  logic [NUM_CH-1:0] ackPulse,
  output logic [NUM_CH-1:0] irqReq
);
  busStrobe_t strb;

  ext_irq_ctl #(.ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .ST_ADDR(ST_ADDR)) u_ctl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strb   (strb)
  );

  ext_irq_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdata    (busWdata),
    .irqPin   (irqPin),
    .senseEdge(senseEdge),
    .ackPulse (ackPulse),
    .rdata    (busRdata),
    .irqReq   (irqReq)
  );
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int              NUM_CH  = 6,
  parameter int              DATA_W  = 8,
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'hF5,
  parameter logic [ADDR_W-1:0] ST_ADDR = 8'hF6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [NUM_CH-1:0] senseEdge,
  input logic [NUM_CH-1:0] ackPulse,
  input logic [NUM_CH-1:0] irqReq,
  input logic [NUM_CH-1:0] flagQ,
  input logic [NUM_CH-1:0] enQ,
  input logic [NUM_CH-1:0] armQ,
  input logic [NUM_CH-1:0] syncQ,
  input logic [NUM_CH-1:0] prevQ
);
  logic [NUM_CH-1:0] swZero, setObs;
  logic enWrObs;

  assign swZero  = (busWrEn && busAddr == ST_ADDR) ? ~busWdata[NUM_CH-1:0] : '0;
  assign enWrObs = busWrEn && busAddr == EN_ADDR;
  assign setObs  = (senseEdge & prevQ & ~syncQ) | (~senseEdge & ~syncQ);

  // R3
  req_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((irqReq & ~enQ) == '0) && ((irqReq & ~flagQ) == '0));

  // R2
  rd_pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:NUM_CH] == '0);

  // R6 R7: a flag only falls through an acknowledge or an armed zero write
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flagQ) & ~flagQ & ~$past(ackPulse) & ~$past(swZero & armQ)) == '0));

  // R8
  level_ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flagQ & ackPulse & ~senseEdge & ~syncQ) & ~flagQ) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(setObs) & ~flagQ) == '0));

  // R11
  en_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    enWrObs |=> enQ == $past(busWdata[NUM_CH-1:0]));
endmodule

bind ext_irq_ctrl ext_irq_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .EN_ADDR(EN_ADDR), .ST_ADDR(ST_ADDR)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .senseEdge(senseEdge),
  .ackPulse (ackPulse),
  .irqReq   (irqReq),
  .flagQ    (u_dp.flagQ),
  .enQ      (u_dp.enQ),
  .armQ     (u_dp.armQ),
  .syncQ    (u_dp.syncQ),
  .prevQ    (u_dp.prevQ)
);

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_EN = 8'hF5;
  localparam logic [7:0] A_ST = 8'hF6;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] busAddr, busWdata, busRdata;
  logic       busWrEn, busRdEn;
  logic [5:0] irqPin, senseEdge, ackPulse, irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWdata(busWdata), .busRdata(busRdata),
    .irqPin(irqPin), .senseEdge(senseEdge), .ackPulse(ackPulse), .irqReq(irqReq)
  );

  // Reference model built from the requirements
  logic [5:0] mS1, mS2, mPrev, mFlag, mArm, mEn;

  function automatic logic [5:0] mSet(input logic [5:0] s2, prev, sense);
    return (sense & prev & ~s2) | (~sense & ~s2);
  endfunction

  function automatic logic [5:0] mHwClr(input logic [5:0] s2, sense, ack);
    return ack & (sense | s2);
  endfunction

  function automatic logic [7:0] mRead(input logic [7:0] a);
    if (a == A_EN) return {2'b00, mEn};
    if (a == A_ST) return {2'b00, mFlag};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 <= '1; mS2 <= '1; mPrev <= '1;
      mFlag <= '0; mArm <= '0; mEn <= '0;
    end else begin
      logic [5:0] hw, sw;
      hw = mHwClr(mS2, senseEdge, ackPulse);
      sw = (busWrEn && busAddr == A_ST) ? (~busWdata[5:0] & mArm) : 6'h00;
      mS1 <= irqPin; mS2 <= mS1; mPrev <= mS2;
      mFlag <= mSet(mS2, mPrev, senseEdge) | (mFlag & ~(hw | sw));
      if (busWrEn && busAddr == A_ST) mArm <= '0;
      else mArm <= (mArm | ((busRdEn && busAddr == A_ST) ? mFlag : 6'h00)) & ~hw;
      if (busWrEn && busAddr == A_EN) mEn <= busWdata[5:0];
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0; ackPulse = '0;
  endtask

  task automatic waitN(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    step();
  endtask

  task automatic doRead(input logic [7:0] a, input logic [7:0] exp, input string req);
    busAddr = a; busRdEn = 1'b1;
    #1 check(req, busRdata, exp);
    step();
  endtask

  task automatic checkReq(input string req, input logic [5:0] exp);
    check(req, {2'b00, irqReq}, {2'b00, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busWdata = '0; busWrEn = 1'b0; busRdEn = 1'b0;
    irqPin = '1; senseEdge = '0; ackPulse = '0;
    void'($urandom(32'h5eed_1a7e));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkReq("R1", 6'h00);
    doRead(A_EN, 8'h00, "R1");
    doRead(A_ST, 8'h00, "R1");

    // R11 R2 enable register and map
    doWrite(A_EN, 8'hFF);
    doRead(A_EN, 8'h3F, "R11 R2");
    doRead(8'h10, 8'h00, "R2");

    // R4 level latency on channel 0
    irqPin[0] = 1'b0;
    waitN(2); checkReq("R4", 6'h00);
    step();   checkReq("R4", 6'h01);
    irqPin[0] = 1'b1; waitN(3);

    // R6 R7 write one, unarmed write zero, then armed clear
    doWrite(A_ST, 8'hFF);
    doWrite(A_ST, 8'h00);
    doRead(A_ST, 8'h01, "R6 R7");
    doWrite(A_ST, 8'h00);
    doRead(A_ST, 8'h00, "R7");

    // R8 level acknowledge: held while pin low, clears when high
    irqPin[1] = 1'b0; waitN(3);
    checkReq("R4", 6'h02);
    ackPulse[1] = 1'b1; step();
    doRead(A_ST, 8'h02, "R8");
    irqPin[1] = 1'b1; waitN(3);
    ackPulse[1] = 1'b1; step();
    doRead(A_ST, 8'h00, "R8");

    // R3 masking
    irqPin[1] = 1'b0; waitN(3);
    doWrite(A_EN, 8'h3D);
    checkReq("R3", 6'h00);
    doRead(A_ST, 8'h02, "R3");
    doWrite(A_EN, 8'h3F);
    checkReq("R3", 6'h02);
    irqPin[1] = 1'b1; waitN(3);
    ackPulse[1] = 1'b1; step();
    checkReq("R8", 6'h00);

    // R5 R9 edge mode on channel 2
    senseEdge[2] = 1'b1;
    irqPin[2] = 1'b0; waitN(3);
    checkReq("R5", 6'h04);
    ackPulse[2] = 1'b1; step();
    checkReq("R9", 6'h00);
    waitN(3);
    checkReq("R5", 6'h00);
    irqPin[2] = 1'b1; waitN(3);

    // R10 acknowledge in the cycle the edge sets the flag
    senseEdge[3] = 1'b1;
    irqPin[3] = 1'b0; waitN(2);
    ackPulse[3] = 1'b1; step();
    checkReq("R10", 6'h08);
    ackPulse[3] = 1'b1; step();
    checkReq("R9", 6'h00);
    irqPin[3] = 1'b1; waitN(3);

    // Random phase against the model
    for (int cyc = 0; cyc < 6000; cyc++) begin
      for (int b = 0; b < 6; b++) if ($urandom_range(0, 7) == 0) irqPin[b] = ~irqPin[b];
      if (cyc % 256 == 0) senseEdge = 6'($urandom);
      for (int b = 0; b < 6; b++) ackPulse[b] = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 9))
        0: begin busAddr = A_EN; busRdEn = 1'b1; end
        1, 2: begin busAddr = A_ST; busRdEn = 1'b1; end
        3: begin busAddr = A_ST; busWdata = 8'($urandom); busWrEn = 1'b1; end
        4: begin busAddr = A_ST; busWdata = 8'h00; busWrEn = 1'b1; end
        5: begin busAddr = A_EN; busWdata = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF; busWrEn = 1'b1; end
        6: begin busAddr = 8'($urandom); busRdEn = 1'b1; end
        default: ;
      endcase
      #1 if (busRdEn) check("R2 R7 read", busRdata, mRead(busAddr));
      step();
      checkReq("R3 R4 R5 R8 R9 R10 random", mFlag & mEn);
    end

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule